// File: doc/BRIEF.md
# RC4 Stream Cipher Word Engine

This block runs the RC4 stream cipher over a message that software feeds in as 32-bit words. Software first stores a key of 1 to 16 bytes in a small bank of key words. It then writes the key length, which starts the key schedule. While the schedule runs the unit reports busy. When it is idle again, each write to the message address XORs keystream bytes into that word, one byte per clock. The result is latched into a cipher output. Encryption and decryption are the same operation.

A 3-bit byte-count register tells the unit two things about the next message word: how many of its bytes are valid, and whether it closes the message. Bytes that are not valid pass through unchanged and draw no keystream. After a word marked as the last one, the unit runs the key schedule again with the stored key. The next message therefore starts from a fresh keystream, and the cipher output keeps the final result.

All access uses a single-cycle write strobe. The cipher word and the status flags are plain level outputs, and there is no back-pressure. A message write that arrives while the unit is busy is dropped and raises an error flag. Software is expected to poll `busy` or `sub_done` before it writes.

Top module: `rc4_stream_unit`

## Requirements
- R1: After reset, `busy`, `sub_done`, `msg_done` and `wr_err` are 0 and `cipher_q` is 0.
- R2: When idle, a write to address 4 sets the key length from `wr_data[4:0]`, where values 1 to 16 are used as given and 0 or 17 to 31 mean 16. The write clears `wr_err` and starts the key schedule. `busy` is high for exactly 257 cycles: 1 initialisation cycle plus 256 schedule steps.
- R3: A write to address k (0 to 3) stores key bytes 4k to 4k+3, with byte 4k taken from bits 31:24 and byte 4k+3 from bits 7:0. The schedule uses key byte (i mod length) at step i.
- R4: The keystream is the standard RC4 output generator starting from i = j = 0 after the schedule. Keystream byte m of a word is XORed into bits 31-8m down to 24-8m, so the most significant byte comes first.
- R5: A write to address 5 sets the next word's valid-byte count to `wr_data[1:0]`+1 and its last-word flag to `wr_data[2]`. Once a message word is accepted, the setting returns to 4 bytes and not last.
- R6: In a word with n valid bytes, the bytes below the top n are copied unchanged from the written word into `cipher_q`.
- R7: Each word uses exactly n keystream bytes, and the next word continues the same keystream.
- R8: When idle, a write to address 6 is accepted and clears `sub_done` and `msg_done`. `busy` is then high for exactly n cycles. After that, `cipher_q` holds the result and `sub_done` is 1. `cipher_q` changes only when `sub_done` rises.
- R9: When the word flagged as last completes, `msg_done` and `sub_done` are set. The unit then re-runs the schedule with the stored key and length, so `busy` stays high for n+257 cycles in total. `cipher_q` keeps that word's result, and the next word starts a fresh keystream.
- R10: A message write while `busy` is high is ignored: it consumes no keystream and leaves `cipher_q` unchanged. It also sets `wr_err`, which stays set until the next idle key-length write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_addr | input | 3 | 0-3 key words, 4 key length, 5 byte count, 6 message |
| wr_data | input | 32 | Write data |
| cipher_q | output | 32 | Last processed word |
| busy | output | 1 | Schedule or word processing in progress |
| sub_done | output | 1 | A word has completed since the last accepted message write |
| msg_done | output | 1 | The completed word was flagged as last |
| wr_err | output | 1 | A message write was dropped while busy |

## Verification
Keys of length 1, 5 and 16, plus the out-of-range value 0, are each run through every valid-byte count from 1 to 4. A bench model of RC4 supplies the expected results. Partial words show whether the unused low bytes pass through and whether only n keystream bytes are consumed, because a miscount shifts every later word. A word sent without a prior byte-count write shows that the count reverts to 4. A last-flagged word followed by a plain word shows whether the schedule restarts from the stored key. A write during processing must leave the cipher output and the keystream position untouched.

// File: rtl/rc4_unit_pkg.sv
package rc4_unit_pkg;
  typedef enum logic [1:0] {SB_HOLD, SB_INIT, SB_KSA, SB_PRGA} sb_cmd_e;
  typedef enum logic [1:0] {ST_IDLE, ST_INIT, ST_KSA, ST_GEN} unit_st_e;
endpackage

// File: rtl/rc4_keystore.sv
module rc4_keystore #(
  parameter int KEY_WORDS = 4,
  localparam int KEY_BYTES = 4 * KEY_WORDS,
  localparam int KW = $clog2(KEY_WORDS),
  localparam int IW = $clog2(KEY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [KW-1:0] wr_sel,
  input  logic [31:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);
  logic [7:0] key_q [KEY_BYTES];

  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q[4*w+b] <= '0;
        else if (wr_en && wr_sel == KW'(w)) key_q[4*w+b] <= wr_data[31-8*b -: 8];
      end
    end
  end

  assign rd_byte = key_q[rd_idx];
endmodule

// File: rtl/rc4_sbox.sv
module rc4_sbox
  import rc4_unit_pkg::*;
#(
  parameter int KEY_BYTES = 16,
  localparam int LW = $clog2(KEY_BYTES + 1),
  localparam int IW = $clog2(KEY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sb_cmd_e       cmd,
  input  logic [LW-1:0] key_len,
  input  logic [7:0]    key_byte,
  output logic [IW-1:0] key_idx,
  output logic          ksa_last,
  output logic [7:0]    ks_byte
);
  logic [7:0]    s_q [256];
  logic [7:0]    i_q, j_q;
  logic [LW-1:0] kidx_q;

  // schedule step
  logic [7:0] ksa_j;
  assign ksa_j    = j_q + s_q[i_q] + key_byte;
  assign ksa_last = (i_q == 8'hFF);
  assign key_idx  = kidx_q[IW-1:0];

  // output step, with the swap applied to the output lookup
  logic [7:0] p_i, p_j, p_si, p_sj, p_t;
  assign p_i  = i_q + 8'd1;
  assign p_si = s_q[p_i];
  assign p_j  = j_q + p_si;
  assign p_sj = s_q[p_j];
  assign p_t  = p_si + p_sj;
  always_comb begin
    if (p_t == p_i)      ks_byte = p_sj;
    else if (p_t == p_j) ks_byte = p_si;
    else                 ks_byte = s_q[p_t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) s_q[k] <= 8'(k);
      i_q    <= '0;
      j_q    <= '0;
      kidx_q <= '0;
    end else begin
      case (cmd)
        SB_INIT: begin
          for (int k = 0; k < 256; k++) s_q[k] <= 8'(k);
          i_q    <= '0;
          j_q    <= '0;
          kidx_q <= '0;
        end
        SB_KSA: begin
          s_q[i_q]   <= s_q[ksa_j];
          s_q[ksa_j] <= s_q[i_q];
          i_q        <= i_q + 8'd1;
          j_q        <= ksa_last ? 8'd0 : ksa_j;
          kidx_q     <= (kidx_q == key_len - 1'b1) ? '0 : kidx_q + 1'b1;
        end
        SB_PRGA: begin
          s_q[p_i] <= p_sj;
          s_q[p_j] <= p_si;
          i_q      <= p_i;
          j_q      <= p_j;
        end
        default: ;
      endcase
    end
  end

  // R3: the key index stays inside the programmed length
  p_kidx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SB_KSA) |-> (kidx_q < key_len));

  // R2: every schedule step advances i by one
  p_ksa_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SB_KSA) |=> (i_q == $past(i_q) + 8'd1));
endmodule

// File: rtl/rc4_stream_unit.sv
module rc4_stream_unit
  import rc4_unit_pkg::*;
#(
  parameter int KEY_WORDS = 4,
  localparam int KEY_BYTES = 4 * KEY_WORDS,
  localparam int KW = $clog2(KEY_WORDS),
  localparam int IW = $clog2(KEY_BYTES),
  localparam int LW = $clog2(KEY_BYTES + 1),
  localparam int AW = $clog2(KEY_WORDS + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic [31:0]   cipher_q,
  output logic          busy,
  output logic          sub_done,
  output logic          msg_done,
  output logic          wr_err
);
  localparam logic [AW-1:0] A_KLEN = AW'(KEY_WORDS);
  localparam logic [AW-1:0] A_BCNT = AW'(KEY_WORDS + 1);
  localparam logic [AW-1:0] A_MSG  = AW'(KEY_WORDS + 2);

  unit_st_e      st_q;
  logic [LW-1:0] len_q;
  logic [1:0]    bc_q, nb_q, cnt_q;
  logic          last_q, wlast_q;
  logic [31:0]   word_q;

  logic key_wr, klen_wr, bcnt_wr, msg_wr;
  assign key_wr  = wr_en && (wr_addr < A_KLEN);
  assign klen_wr = wr_en && (wr_addr == A_KLEN);
  assign bcnt_wr = wr_en && (wr_addr == A_BCNT);
  assign msg_wr  = wr_en && (wr_addr == A_MSG);
  assign busy    = (st_q != ST_IDLE);

  logic [LW-1:0] len_field, len_eff;
  assign len_field = wr_data[LW-1:0];
  assign len_eff   = (len_field == '0 || len_field > LW'(KEY_BYTES)) ? LW'(KEY_BYTES) : len_field;

  logic [IW-1:0] key_idx;
  logic [7:0]    key_byte, ks_byte;
  logic          ksa_last;
  sb_cmd_e       sb_cmd;

  rc4_keystore #(.KEY_WORDS(KEY_WORDS)) u_keys (
    .clk(clk), .rst_n(rst_n), .wr_en(key_wr), .wr_sel(wr_addr[KW-1:0]),
    .wr_data(wr_data), .rd_idx(key_idx), .rd_byte(key_byte)
  );

  rc4_sbox #(.KEY_BYTES(KEY_BYTES)) u_sbox (
    .clk(clk), .rst_n(rst_n), .cmd(sb_cmd), .key_len(len_q), .key_byte(key_byte),
    .key_idx(key_idx), .ksa_last(ksa_last), .ks_byte(ks_byte)
  );

  always_comb begin
    case (st_q)
      ST_INIT: sb_cmd = SB_INIT;
      ST_KSA:  sb_cmd = SB_KSA;
      ST_GEN:  sb_cmd = SB_PRGA;
      default: sb_cmd = SB_HOLD;
    endcase
  end

  // byte cnt_q sits at bit offset 8*(3-cnt_q)
  logic [4:0]  byte_sh;
  logic [31:0] next_word;
  assign byte_sh   = {~cnt_q, 3'b000};
  assign next_word = word_q ^ ({24'b0, ks_byte} << byte_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      len_q    <= LW'(KEY_BYTES);
      bc_q     <= 2'd3;
      last_q   <= 1'b0;
      nb_q     <= 2'd3;
      cnt_q    <= '0;
      wlast_q  <= 1'b0;
      word_q   <= '0;
      cipher_q <= '0;
      sub_done <= 1'b0;
      msg_done <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      if (bcnt_wr) begin
        bc_q   <= wr_data[1:0];
        last_q <= wr_data[2];
      end
      case (st_q)
        ST_IDLE: begin
          if (klen_wr) begin
            len_q  <= len_eff;
            wr_err <= 1'b0;
            st_q   <= ST_INIT;
          end else if (msg_wr) begin
            word_q   <= wr_data;
            nb_q     <= bc_q;
            wlast_q  <= last_q;
            bc_q     <= 2'd3;
            last_q   <= 1'b0;
            cnt_q    <= '0;
            sub_done <= 1'b0;
            msg_done <= 1'b0;
            st_q     <= ST_GEN;
          end
        end
        ST_INIT: st_q <= ST_KSA;
        ST_KSA:  if (ksa_last) st_q <= ST_IDLE;
        ST_GEN: begin
          word_q <= next_word;
          if (cnt_q == nb_q) begin
            cipher_q <= next_word;
            sub_done <= 1'b1;
            msg_done <= wlast_q;
            st_q     <= wlast_q ? ST_INIT : ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (msg_wr && busy) wr_err <= 1'b1;
    end
  end

  // R10: a message write during busy raises the error flag
  p_err_on_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_wr && busy) |=> wr_err);

  // R8: the result register only moves when a word completes
  p_cipher_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sub_done) |-> $stable(cipher_q));

  // R9: a completed last word leads straight into re-initialisation
  p_last_reinit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_done) |-> (st_q == ST_INIT));

  // R9: message completion implies word completion
  p_msg_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> sub_done);

  // R7: never more keystream bytes than valid bytes
  p_gen_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GEN) |-> (cnt_q <= nb_q));

  // R5: an accepted word returns the byte-count setting to its default
  p_bc_revert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_wr && !busy && !klen_wr) |=> (bc_q == 2'd3 && !last_q));
endmodule

// File: tb/rc4_stream_unit_test.sv
module rc4_stream_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] cipher_q;
  logic        busy, sub_done, msg_done, wr_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rc4_stream_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cipher_q(cipher_q), .busy(busy), .sub_done(sub_done), .msg_done(msg_done), .wr_err(wr_err)
  );

  // bench RC4 model
  int rs[256];
  int ri, rj, cur_len;
  int keyb[16];

  task automatic ref_sched(input int len);
    int jj = 0;
    for (int k = 0; k < 256; k++) rs[k] = k;
    for (int k = 0; k < 256; k++) begin
      int t;
      jj = (jj + rs[k] + keyb[k % len]) % 256;
      t = rs[k]; rs[k] = rs[jj]; rs[jj] = t;
    end
    ri = 0; rj = 0;
  endtask

  task automatic ref_next(output logic [7:0] b);
    int t;
    ri = (ri + 1) % 256;
    rj = (rj + rs[ri]) % 256;
    t = rs[ri]; rs[ri] = rs[rj]; rs[rj] = t;
    b = 8'(rs[(rs[ri] + rs[rj]) % 256]);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int c);
    c = 0;
    while (busy && c < 2000) begin
      c++;
      @(negedge clk);
    end
  endtask

  // R2 R3: load key bytes, start schedule, check busy length
  task automatic load_key(input int lv, input int seed);
    int c;
    for (int b = 0; b < 16; b++) keyb[b] = (seed + 37 * b + b * b) % 256;
    for (int w = 0; w < 4; w++)
      bus_wr(3'(w), {8'(keyb[4*w]), 8'(keyb[4*w+1]), 8'(keyb[4*w+2]), 8'(keyb[4*w+3])});
    cur_len = (lv == 0 || lv > 16) ? 16 : lv;
    bus_wr(3'd4, 32'(lv));
    wait_idle(c);
    chk(c == 257, "R2 schedule busy cycles", 32'(c), 32'd257);
    chk(wr_err == 1'b0, "R2 key length write clears error", {31'b0, wr_err}, 32'd0);
    ref_sched(cur_len);
  endtask

  // R4 R5 R6 R7 R8 R9: one message word
  task automatic send_word(input int n, input bit last, input bit set_bc, input logic [31:0] d);
    logic [31:0] e;
    logic [7:0]  b;
    int c, expc;
    if (set_bc) bus_wr(3'd5, {29'b0, last, 2'(n - 1)});
    e = d;
    for (int k = 0; k < n; k++) begin
      ref_next(b);
      e[31-8*k -: 8] = e[31-8*k -: 8] ^ b;
    end
    bus_wr(3'd6, d);
    wait_idle(c);
    expc = last ? n + 257 : n;
    chk(c == expc, "R8 R9 word busy cycles", 32'(c), 32'(expc));
    chk(cipher_q == e, "R4 R6 R7 cipher word", cipher_q, e);
    chk(sub_done == 1'b1, "R8 sub done", {31'b0, sub_done}, 32'd1);
    chk(msg_done == last, "R9 message done flag", {31'b0, msg_done}, {31'b0, last});
    if (last) ref_sched(cur_len);
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual busy %0d expected idle", busy);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lens[4] = '{1, 5, 16, 0};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", {31'b0, busy}, 32'd0);
    chk(sub_done == 1'b0, "R1 sub done after reset", {31'b0, sub_done}, 32'd0);
    chk(msg_done == 1'b0, "R1 msg done after reset", {31'b0, msg_done}, 32'd0);
    chk(wr_err == 1'b0, "R1 error after reset", {31'b0, wr_err}, 32'd0);
    chk(cipher_q == 32'd0, "R1 cipher after reset", cipher_q, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (lens[q]) begin
      load_key(lens[q], 17 + 59 * q);
      for (int n = 1; n <= 4; n++)
        send_word(n, 1'b0, 1'b1, 32'hA5C3_0F96 ^ (32'(n) * 32'h0123_4567) ^ (32'(q) << 9));
      // R5: after a partial word the count reverts to four bytes
      send_word(2, 1'b0, 1'b1, 32'h1357_9BDF);
      send_word(4, 1'b0, 1'b0, 32'h2468_ACE0 ^ 32'(q));
      // R9: last word then fresh keystream
      send_word(3, 1'b1, 1'b1, 32'hDEAD_BEEF ^ 32'(q));
      send_word(4, 1'b0, 1'b0, 32'h0F1E_2D3C);
      send_word(1, 1'b1, 1'b1, 32'h7788_99AA);
      send_word(4, 1'b0, 1'b0, 32'h0F1E_2D3C);
    end

    // R10: write while busy is dropped and flagged
    begin
      logic [31:0] e;
      logic [7:0]  b;
      int c;
      e = 32'h5555_AAAA;
      for (int k = 0; k < 4; k++) begin
        ref_next(b);
        e[31-8*k -: 8] = e[31-8*k -: 8] ^ b;
      end
      bus_wr(3'd6, 32'h5555_AAAA);
      bus_wr(3'd6, 32'hFFFF_0000);
      chk(wr_err == 1'b1, "R10 error flag on busy write", {31'b0, wr_err}, 32'd1);
      wait_idle(c);
      chk(cipher_q == e, "R10 busy write ignored", cipher_q, e);
      chk(wr_err == 1'b1, "R10 error flag holds", {31'b0, wr_err}, 32'd1);
      send_word(4, 1'b0, 1'b0, 32'h0000_0000);
      load_key(7, 201);
      send_word(4, 1'b0, 1'b0, 32'h1234_5678);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule